// File: doc/BRIEF.md
# Decode-Stage Branch Unit with Delay Slot

This block owns the program counter of a five-stage in-order pipeline and settles every control transfer in the decode stage. It holds the fetch address and the fetch/decode register, which records the address of the instruction now in decode and whether that slot is valid. It also contains an equality comparator on the two register operands and the logic that selects the next fetch address: sequential, PC-relative branch, absolute jump or register jump.

A transfer is resolved while the branch sits in decode. By that point the following instruction has already been fetched, and it always executes. That instruction is the delay slot. A taken transfer therefore loads the target into the PC at the same edge that moves the delay slot into decode, so no cycle is lost and nothing is flushed. Once a branch leaves decode, the later stages do nothing for it. The surrounding pipeline presents the decoded class, the two operand values, the sign-extended offset and the jump index of the decode-stage instruction. It raises a stall input to freeze fetch.

Top module: `dsb_branch_unit`

## Requirements
- R1: While reset is low at a clock edge, the fetch address becomes 0 and the decode slot becomes invalid. The first fetch of address 0 follows on the next clock.
- R2: With no stall and no redirect, each clock adds 4 to the fetch address, copies the old fetch address into the decode address and marks decode valid.
- R3: Class code 1 (branch-if-equal) is taken when operand A equals operand B. Its target is the decode address plus 4, plus the offset shifted left by two. The fetch address takes that target at the next clock.
- R4: Class code 2 (branch-if-not-equal) is taken when operand A differs from operand B, and uses the same target as R3.
- R5: An untaken conditional branch raises no redirect, and fetch continues sequentially with no lost cycle.
- R6: After any taken transfer, the instruction in decode on the next cycle is the delay slot at the transfer's address plus 4, and it is valid.
- R7: Class code 3 (jump) is always taken. Its target is bits 31..28 of the delay-slot address, then the 26-bit jump index, then two zero bits.
- R8: Class code 4 (register jump) is always taken. Its target is operand A with bits 1..0 forced to zero.
- R9: While stall is high, the fetch address, decode address and decode valid hold, and no redirect is raised.
- R10: Class codes 0, 5, 6 and 7 raise no redirect.
- R11: While the decode slot is invalid, the class input is ignored and no redirect is raised.
- R12: A negative offset gives a backward target computed with sign, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and decode, suppress redirect |
| id_class_i | input | 3 | Control class of the decode-stage instruction |
| id_opa_i | input | XLEN | Operand A (first register value) |
| id_opb_i | input | XLEN | Operand B (second register value) |
| id_offset_i | input | XLEN | Sign-extended word offset |
| id_jidx_i | input | XLEN-6 | Absolute jump word index |
| fetch_pc_o | output | XLEN | Address being fetched |
| id_pc_o | output | XLEN | Address of the instruction in decode |
| id_valid_o | output | 1 | Decode slot holds a fetched instruction |
| redirect_o | output | 1 | Transfer taken this cycle |
| target_o | output | XLEN | Address loaded on redirect |

## Verification
The bench targets the delay-slot timing. A design that flushed the slot, or redirected one cycle late, would show the wrong decode address right after a taken branch. It also drives a branch with equal operands in the cycle just after reset, when decode is still empty; a unit that ignored the valid flag would jump from garbage. Further cases are stalls that coincide with a taken branch, where a leaky design would commit the redirect or move the PC, and backward offsets, where a zero-extending adder would land far ahead. Register jumps to odd addresses are covered, as are jumps taken from a high address region, which catch a wrong upper-bit source.

// File: rtl/dsb_pkg.sv
// Shared encodings for the decode-stage branch unit.
package dsb_pkg;

    // Control class presented by the decoder for the instruction in decode.
    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_BEQ  = 3'd1,
        CLS_BNE  = 3'd2,
        CLS_JMP  = 3'd3,
        CLS_JREG = 3'd4
    } ctl_class_e;

    // Which target adder feeds the redirect address.
    typedef enum logic [1:0] {
        TGT_REL = 2'd0,
        TGT_ABS = 2'd1,
        TGT_REG = 2'd2
    } tgt_kind_e;

endpackage

// File: rtl/dsb_decide.sv
// Branch decision: compares the two decode operands lane by lane and decides
// whether the decode-stage instruction redirects fetch. Assumes the class
// input is meaningful only while the decode slot is valid.
module dsb_decide
    import dsb_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic            id_valid_i,
    input  logic            stall_i,
    input  logic [2:0]      cls_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            take_o,
    output tgt_kind_e       kind_o
);
    localparam int LANES = XLEN / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic             ops_eq;
    logic             cond;
    ctl_class_e       cls;

    // Per-lane equality, reduced below into one match bit.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (opa_i[g*LANE_W +: LANE_W] == opb_i[g*LANE_W +: LANE_W]);
    end

    assign ops_eq = &lane_eq;
    assign cls    = ctl_class_e'(cls_i);

    // Map the class to a condition and a target source.
    always_comb begin
        cond   = 1'b0;
        kind_o = TGT_REL;
        case (cls)
            CLS_BEQ:  begin cond = ops_eq;  kind_o = TGT_REL; end
            CLS_BNE:  begin cond = !ops_eq; kind_o = TGT_REL; end
            CLS_JMP:  begin cond = 1'b1;    kind_o = TGT_ABS; end
            CLS_JREG: begin cond = 1'b1;    kind_o = TGT_REG; end
            default:  begin cond = 1'b0;    kind_o = TGT_REL; end
        endcase
    end

    // Commit only for a valid, unstalled decode slot.
    assign take_o = id_valid_i && !stall_i && cond;

endmodule

// File: rtl/dsb_target.sv
// Target generation: forms the redirect address from the delay-slot address,
// the offset, the jump index or operand A. Purely combinational.
module dsb_target
    import dsb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  tgt_kind_e         kind_i,
    input  logic [XLEN-1:0]   slot_pc_i,
    input  logic [XLEN-1:0]   offset_i,
    input  logic [XLEN-7:0]   jidx_i,
    input  logic [XLEN-1:0]   opa_i,
    output logic [XLEN-1:0]   target_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    // Select among PC-relative, region-absolute and register targets.
    always_comb begin
        case (kind_i)
            TGT_ABS: target_o = {slot_pc_i[XLEN-1:XLEN-4], jidx_i, 2'b00};
            TGT_REG: target_o = opa_i & ALIGN_MASK;
            default: target_o = slot_pc_i + (offset_i << 2);
        endcase
    end

endmodule

// File: rtl/dsb_pcreg.sv
// PC and fetch/decode register. Holds under stall, loads the target on a
// taken transfer, otherwise steps by one word. The delay slot is the
// instruction fetched in the same cycle the transfer is decided.
module dsb_pcreg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            take_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic [XLEN-1:0] id_pc_o,
    output logic            id_valid_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] next_pc;

    // Next fetch address: target on a taken transfer, else sequential.
    assign next_pc = take_i ? target_i : fetch_pc_o + STEP;

    // Fetch address register.
    always_ff @(posedge clk) begin
        if (!rst_n)        fetch_pc_o <= RESET_PC;
        else if (!stall_i) fetch_pc_o <= next_pc;
    end

    // Fetch/decode register: address and validity of the decode instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_pc_o    <= '0;
            id_valid_o <= 1'b0;
        end else if (!stall_i) begin
            id_pc_o    <= fetch_pc_o;
            id_valid_o <= 1'b1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc_o == RESET_PC && !id_valid_o));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall_i) && !$past(take_i))
            |-> (fetch_pc_o == $past(fetch_pc_o) + STEP));

    p_target_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_i)) |-> (fetch_pc_o == $past(target_i)));

    p_slot_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_i))
            |-> (id_valid_o && id_pc_o == $past(fetch_pc_o)));

    p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stall_i))
            |-> ($stable(fetch_pc_o) && $stable(id_pc_o) && $stable(id_valid_o)));

endmodule

// File: rtl/dsb_branch_unit.sv
// Decode-stage branch unit: PC, fetch/decode register, comparator and
// next-PC selection for a pipeline with a single architectural delay slot.
// Assumes the decoder supplies class and operands for the decode instruction
// in the same cycle, and that no transfer is placed in a delay slot.
module dsb_branch_unit
    import dsb_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              LANE_W   = 8,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic [2:0]      id_class_i,
    input  logic [XLEN-1:0] id_opa_i,
    input  logic [XLEN-1:0] id_opb_i,
    input  logic [XLEN-1:0] id_offset_i,
    input  logic [XLEN-7:0] id_jidx_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic [XLEN-1:0] id_pc_o,
    output logic            id_valid_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] target_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] slot_pc;
    tgt_kind_e       kind;
    logic            take;

    // Address of the delay slot that follows the decode instruction.
    assign slot_pc = id_pc_o + STEP;

    dsb_decide #(.XLEN(XLEN), .LANE_W(LANE_W)) u_decide (
        .id_valid_i (id_valid_o),
        .stall_i    (stall_i),
        .cls_i      (id_class_i),
        .opa_i      (id_opa_i),
        .opb_i      (id_opb_i),
        .take_o     (take),
        .kind_o     (kind)
    );

    dsb_target #(.XLEN(XLEN)) u_target (
        .kind_i    (kind),
        .slot_pc_i (slot_pc),
        .offset_i  (id_offset_i),
        .jidx_i    (id_jidx_i),
        .opa_i     (id_opa_i),
        .target_o  (target_o)
    );

    dsb_pcreg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pcreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_i    (stall_i),
        .take_i     (take),
        .target_i   (target_o),
        .fetch_pc_o (fetch_pc_o),
        .id_pc_o    (id_pc_o),
        .id_valid_o (id_valid_o)
    );

    assign redirect_o = take;

    p_beq_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid_o && !stall_i && id_class_i == 3'd1 && id_opa_i == id_opb_i)
            |-> (redirect_o && target_o == id_pc_o + STEP + (id_offset_i << 2)));

    p_bne_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid_o && !stall_i && id_class_i == 3'd2)
            |-> (redirect_o == (id_opa_i != id_opb_i)));

    p_aligned_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (target_o[1:0] == 2'b00));

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !redirect_o);

    p_rsvd_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (id_class_i == 3'd0 || id_class_i >= 3'd5) |-> !redirect_o);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid_o |-> !redirect_o);

endmodule

// File: tb/sim_dsb_branch_unit.sv
module sim_dsb_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [2:0]  id_class_i = 3'd0;
    logic [31:0] id_opa_i = '0;
    logic [31:0] id_opb_i = '0;
    logic [31:0] id_offset_i = '0;
    logic [25:0] id_jidx_i = '0;
    logic [31:0] fetch_pc_o, id_pc_o, target_o;
    logic        id_valid_o, redirect_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model of architectural state.
    logic [31:0] m_pc = '0;
    logic [31:0] m_idpc = '0;
    logic        m_idv = 1'b0;

    // Scoreboard queues: expected state after each clock.
    logic [31:0] q_pc[$];
    logic [31:0] q_idpc[$];
    logic        q_idv[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    dsb_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .id_class_i(id_class_i),
        .id_opa_i(id_opa_i), .id_opb_i(id_opb_i), .id_offset_i(id_offset_i),
        .id_jidx_i(id_jidx_i), .fetch_pc_o(fetch_pc_o), .id_pc_o(id_pc_o),
        .id_valid_o(id_valid_o), .redirect_o(redirect_o), .target_o(target_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: after each edge, pop the expected state and compare.
    always @(posedge clk) begin
        #2;
        if (q_pc.size() > 0) begin
            logic [31:0] e_pc, e_idpc;
            logic        e_idv;
            string       t;
            e_pc = q_pc.pop_front();
            e_idpc = q_idpc.pop_front();
            e_idv = q_idv.pop_front();
            t = q_tag.pop_front();
            check(fetch_pc_o == e_pc, {t, " fetch_pc"}, fetch_pc_o, e_pc);
            check(id_valid_o == e_idv, {t, " id_valid"}, 32'(id_valid_o), 32'(e_idv));
            if (e_idv)
                check(id_pc_o == e_idpc, {t, " id_pc"}, id_pc_o, e_idpc);
        end
    end

    // Driver: one decode cycle; checks redirect, updates model, pushes expectation.
    task automatic cyc(input logic [2:0] cls, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] off, input logic [25:0] jidx, input bit stl,
                       input string tag);
        bit          cond, taken;
        logic [31:0] tgt, slot;
        id_class_i = cls; id_opa_i = a; id_opb_i = b;
        id_offset_i = off; id_jidx_i = jidx; stall_i = stl;
        slot = m_idpc + 32'd4;
        case (cls)
            3'd1: begin cond = (a == b); tgt = slot + {off[29:0], 2'b00}; end
            3'd2: begin cond = (a != b); tgt = slot + {off[29:0], 2'b00}; end
            3'd3: begin cond = 1'b1; tgt = {slot[31:28], jidx, 2'b00}; end
            3'd4: begin cond = 1'b1; tgt = {a[31:2], 2'b00}; end
            default: begin cond = 1'b0; tgt = '0; end
        endcase
        taken = m_idv && !stl && cond;
        #1;
        check(redirect_o == taken, {tag, " redirect"}, 32'(redirect_o), 32'(taken));
        if (taken) check(target_o == tgt, {tag, " target"}, target_o, tgt);
        if (!stl) begin
            m_idpc = m_pc;
            m_idv = 1'b1;
            m_pc = taken ? tgt : m_pc + 32'd4;
        end
        q_pc.push_back(m_pc);
        q_idpc.push_back(m_idpc);
        q_idv.push_back(m_idv);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic nop(input string tag);
        cyc(3'd0, 32'd0, 32'd0, 32'd0, 26'd0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fetch_pc_o == 32'd0, "R1 reset fetch_pc", fetch_pc_o, 32'd0);
        check(id_valid_o == 1'b0, "R1 reset id_valid", 32'(id_valid_o), 32'd0);
        rst_n = 1'b1;
        // R11: branch with equal operands while decode is empty
        cyc(3'd1, 32'd7, 32'd7, 32'd40, 26'd0, 1'b0, "R11 idle slot");
        // R2: sequential flow
        nop("R2 seq");
        nop("R2 seq");
        // R3: beq taken forward, then R6 delay slot in decode
        cyc(3'd1, 32'h55, 32'h55, 32'd5, 26'd0, 1'b0, "R3 beq taken");
        nop("R6 delay slot");
        nop("R2 seq after target");
        // R5: beq not taken
        cyc(3'd1, 32'h1, 32'h2, 32'd9, 26'd0, 1'b0, "R5 beq not taken");
        nop("R5 seq");
        // R4 and R12: bne taken backward
        cyc(3'd2, 32'h10, 32'h11, 32'hFFFF_FFFD, 26'd0, 1'b0, "R4 R12 bne backward");
        nop("R6 slot after bne");
        // R4: bne not taken on equal
        cyc(3'd2, 32'h3C, 32'h3C, 32'd2, 26'd0, 1'b0, "R4 bne equal not taken");
        // R8: register jump to an odd address, into a high region
        cyc(3'd4, 32'hA000_0103, 32'd0, 32'd0, 26'd0, 1'b0, "R8 jreg");
        nop("R6 slot after jreg");
        nop("R2 seq high");
        // R7: jump keeps upper bits of the delay-slot address
        cyc(3'd3, 32'd0, 32'd0, 32'd0, 26'h012_3456, 1'b0, "R7 jump");
        nop("R6 slot after jump");
        // R9: stall with a taken beq held, then released
        cyc(3'd1, 32'h9, 32'h9, 32'd3, 26'd0, 1'b1, "R9 stall holds");
        cyc(3'd1, 32'h9, 32'h9, 32'd3, 26'd0, 1'b1, "R9 stall holds again");
        cyc(3'd1, 32'h9, 32'h9, 32'd3, 26'd0, 1'b0, "R9 released beq");
        nop("R6 slot after stall");
        // R10: reserved class codes
        cyc(3'd5, 32'h1, 32'h1, 32'd4, 26'h3, 1'b0, "R10 class5");
        cyc(3'd6, 32'h1, 32'h2, 32'd4, 26'h3, 1'b0, "R10 class6");
        cyc(3'd7, 32'h1, 32'h1, 32'd4, 26'h3, 1'b0, "R10 class7");
        nop("R10 class0");
        nop("R2 drain");
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule